// File: doc/BRIEF.md
# BCD Calendar Timekeeper with Drift Trim

This block is the counting core of a real-time clock. A slow tick enable, nominally 32768 pulses per second, drives a prescaler. Each time the prescaler completes a second, a packed-BCD calendar advances. The calendar holds seconds, minutes, hours, day of month, month and a two-digit year that stands for 2000 to 2099. Host software uses a byte-wide register port with an address, a write strobe, write data and combinational read data. Through that port it can stop the clock, load a new time, take a coherent copy of the running time and program a signed trim value.

Crystal error is corrected once per hour. At the moment the clock leaves second 00 of minute 00, the prescaler is reloaded from the signed trim value instead of from zero. That one second then lasts longer or shorter by the programmed number of ticks.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the clock is stopped, the control register reads 0x00, both trim bytes read 0x00, and the time bytes at addresses 0..5 read 00,00,00,01,01,00 (2000-01-01 00:00:00).
- R2: Addresses 0 to 5 hold BCD seconds, minutes, hours, day, month and year, in that order. Address 6 is control: bit0 run, bit1 snapshot, bit2 auto-trim. Address 7 is the trim low byte and address 8 is the trim high byte.
- R3: While run is 0 the calendar does not count. A time-byte write made while stopped loads that live field and clears the prescaler. A time-byte write made while running is ignored.
- R4: While running, seconds advance once every 2^PRE_BITS cycles in which tick_en is high.
- R5: Seconds and minutes roll from 59 to 00 and hours from 23 to 00, each carrying into the next field.
- R6: The day rolls to 01 after day 30 in April, June, September and November and after day 31 in the other non-February months. Month 12 rolls to 01 and carries into the year, and year 99 rolls to 00.
- R7: February ends at day 29 when the binary value of the BCD year is divisible by 4, and at day 28 otherwise.
- R8: Writing control with bit1 set copies the live time into the readable copy in that cycle. Reads of addresses 0..5 return the copy and do not follow the running count. Bit1 always reads 0.
- R9: A low trim byte write is only staged. The 16-bit value takes effect when the high byte is written. A commit that would produce 0x7FFF is rejected and the previous value is kept.
- R10: With auto-trim on, the second that starts when seconds step from 00 to 01 while minutes are 00 lasts 2^PRE_BITS + C ticks, where C is the signed trim. That second never lasts fewer than 1 tick, and the following seconds are normal length.
- R11: With auto-trim off, every second lasts 2^PRE_BITS ticks whatever the trim value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Prescaler tick enable (32768 Hz nominal) |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
Read data is combinational: it is valid in the same cycle the address is applied, and the bench samples it 1 ns after driving the address at a falling edge. A snapshot or register write takes effect on the next rising edge, and the bench reads only after that edge. The bench holds tick_en low except inside a tick task that raises it for an exact number of rising edges. Every trim and rollover result is therefore pinned to a tick count, such as 2^PRE_BITS + C - 1 ticks with no step and one more tick with a step, and does not depend on bus timing.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BUS_AW   = 4;
    localparam int BUS_DW   = 8;
    localparam int TRIM_W   = 16;
    localparam int NFIELDS  = 6;

    typedef enum logic [BUS_AW-1:0] {
        REG_SEC    = 4'd0,
        REG_MIN    = 4'd1,
        REG_HR     = 4'd2,
        REG_DAY    = 4'd3,
        REG_MON    = 4'd4,
        REG_YR     = 4'd5,
        REG_CTRL   = 4'd6,
        REG_TRIMLO = 4'd7,
        REG_TRIMHI = 4'd8
    } reg_addr_e;

    localparam int CTL_RUN  = 0;
    localparam int CTL_SNAP = 1;
    localparam int CTL_AUTO = 2;

    localparam logic [TRIM_W-1:0] TRIM_FORBIDDEN = 16'h7FFF;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] day;
        logic [7:0] mon;
        logic [7:0] yr;
    } bcd_time_t;

    localparam bcd_time_t TIME_RESET = '{sec: 8'h00, min: 8'h00, hr: 8'h00,
                                         day: 8'h01, mon: 8'h01, yr: 8'h00};

    function automatic logic [6:0] bcd2bin(input logic [7:0] b);
        return ({3'b000, b[7:4]} * 7'd10) + {3'b000, b[3:0]};
    endfunction

    function automatic logic [7:0] bcd_inc(input logic [7:0] b);
        if (b[3:0] == 4'd9)
            return {b[7:4] + 4'd1, 4'd0};
        return {b[7:4], b[3:0] + 4'd1};
    endfunction

    function automatic logic year_is_leap(input logic [7:0] yr_bcd);
        logic [6:0] yb;
        yb = bcd2bin(yr_bcd);
        return (yb[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] last_day(input logic [7:0] mon_bcd,
                                            input logic [7:0] yr_bcd);
        case (bcd2bin(mon_bcd))
            7'd2:                     return year_is_leap(yr_bcd) ? 8'h29 : 8'h28;
            7'd4, 7'd6, 7'd9, 7'd11:  return 8'h30;
            default:                  return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler
    import rtc_pkg::*;
#(
    parameter int PRE_BITS = 15
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     tick_en,
    input  logic                     run,
    input  logic                     clr,
    input  logic                     trim_fire,
    input  logic signed [TRIM_W-1:0] trim,
    output logic                     sec_pulse
);
    localparam int CNT_W = ((PRE_BITS > TRIM_W) ? PRE_BITS : TRIM_W) + 2;
    localparam logic signed [CNT_W-1:0] LIMIT = CNT_W'((1 << PRE_BITS) - 1);

    logic signed [CNT_W-1:0] cnt_q;
    logic signed [CNT_W-1:0] neg_trim;
    logic signed [CNT_W-1:0] reload;
    logic                    at_top;

    always_comb begin
        neg_trim = -{{(CNT_W-TRIM_W){trim[TRIM_W-1]}}, trim};
        reload   = (neg_trim > LIMIT) ? LIMIT : neg_trim;
    end

    assign at_top    = (cnt_q == LIMIT);
    assign sec_pulse = run && tick_en && at_top;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick_en) begin
            if (at_top)
                cnt_q <= trim_fire ? reload : '0;
            else
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LIMIT);

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sec_pulse,
    input  logic       ld_en,
    input  logic [2:0] ld_idx,
    input  logic [7:0] ld_data,
    output bcd_time_t  live
);
    bcd_time_t cur_q;
    bcd_time_t nxt;
    logic [7:0] dim;

    always_comb begin
        nxt = cur_q;
        dim = last_day(cur_q.mon, cur_q.yr);
        if (cur_q.sec == 8'h59) begin
            nxt.sec = 8'h00;
            if (cur_q.min == 8'h59) begin
                nxt.min = 8'h00;
                if (cur_q.hr == 8'h23) begin
                    nxt.hr = 8'h00;
                    if (cur_q.day == dim) begin
                        nxt.day = 8'h01;
                        if (cur_q.mon == 8'h12) begin
                            nxt.mon = 8'h01;
                            nxt.yr  = (cur_q.yr == 8'h99) ? 8'h00 : bcd_inc(cur_q.yr);
                        end else begin
                            nxt.mon = bcd_inc(cur_q.mon);
                        end
                    end else begin
                        nxt.day = bcd_inc(cur_q.day);
                    end
                end else begin
                    nxt.hr = bcd_inc(cur_q.hr);
                end
            end else begin
                nxt.min = bcd_inc(cur_q.min);
            end
        end else begin
            nxt.sec = bcd_inc(cur_q.sec);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= TIME_RESET;
        end else if (ld_en) begin
            case (ld_idx)
                3'd0:    cur_q.sec <= ld_data;
                3'd1:    cur_q.min <= ld_data;
                3'd2:    cur_q.hr  <= ld_data;
                3'd3:    cur_q.day <= ld_data;
                3'd4:    cur_q.mon <= ld_data;
                default: cur_q.yr  <= ld_data;
            endcase
        end else if (sec_pulse) begin
            cur_q <= nxt;
        end
    end

    assign live = cur_q;

    // R5
    sec_range_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sec_pulse) && $past(cur_q.sec) == 8'h59 && !$past(ld_en) |-> cur_q.sec == 8'h00);

    // R6
    day_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        $past(sec_pulse) && !$past(ld_en) && $past(cur_q.day) != cur_q.day |->
            cur_q.day == 8'h01 || cur_q.day == bcd_inc($past(cur_q.day)));

endmodule

// File: rtl/rtc_hostregs.sv
module rtc_hostregs
    import rtc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [BUS_AW-1:0]        bus_addr,
    input  logic                     bus_wr,
    input  logic [BUS_DW-1:0]        bus_wdata,
    input  bcd_time_t                live,
    output logic                     run,
    output logic                     auto_trim,
    output logic signed [TRIM_W-1:0] trim,
    output logic                     ld_en,
    output logic [2:0]               ld_idx,
    output logic [BUS_DW-1:0]        ld_data,
    output logic [BUS_DW-1:0]        bus_rdata
);
    logic                 run_q;
    logic                 auto_q;
    bcd_time_t            copy_q;
    logic [BUS_DW-1:0]    lo_stage_q;
    logic [TRIM_W-1:0]    trim_q;
    logic [TRIM_W-1:0]    trim_cand;
    logic                 wr_ctrl, wr_lo, wr_hi;

    assign wr_ctrl   = bus_wr && (bus_addr == REG_CTRL);
    assign wr_lo     = bus_wr && (bus_addr == REG_TRIMLO);
    assign wr_hi     = bus_wr && (bus_addr == REG_TRIMHI);
    assign trim_cand = {bus_wdata, lo_stage_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q      <= 1'b0;
            auto_q     <= 1'b0;
            copy_q     <= TIME_RESET;
            lo_stage_q <= '0;
            trim_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                run_q  <= bus_wdata[CTL_RUN];
                auto_q <= bus_wdata[CTL_AUTO];
                if (bus_wdata[CTL_SNAP])
                    copy_q <= live;
            end
            if (wr_lo)
                lo_stage_q <= bus_wdata;
            if (wr_hi && trim_cand != TRIM_FORBIDDEN)
                trim_q <= trim_cand;
        end
    end

    assign run       = run_q;
    assign auto_trim = auto_q;
    assign trim      = trim_q;
    assign ld_en     = bus_wr && (bus_addr <= REG_YR) && !run_q;
    assign ld_idx    = bus_addr[2:0];
    assign ld_data   = bus_wdata;

    always_comb begin
        case (bus_addr)
            REG_SEC:    bus_rdata = copy_q.sec;
            REG_MIN:    bus_rdata = copy_q.min;
            REG_HR:     bus_rdata = copy_q.hr;
            REG_DAY:    bus_rdata = copy_q.day;
            REG_MON:    bus_rdata = copy_q.mon;
            REG_YR:     bus_rdata = copy_q.yr;
            REG_CTRL:   bus_rdata = {5'b00000, auto_q, 1'b0, run_q};
            REG_TRIMLO: bus_rdata = trim_q[7:0];
            REG_TRIMHI: bus_rdata = trim_q[15:8];
            default:    bus_rdata = '0;
        endcase
    end

    // R9
    trim_legal_chk: assert property (@(posedge clk) disable iff (rst)
        trim_q != TRIM_FORBIDDEN);

    // R8
    copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_ctrl && bus_wdata[CTL_SNAP]) |=> $stable(copy_q));

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
    import rtc_pkg::*;
#(
    parameter int PRE_BITS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata
);
    bcd_time_t                live;
    logic                     run, auto_trim, sec_pulse, trim_fire;
    logic signed [TRIM_W-1:0] trim;
    logic                     ld_en;
    logic [2:0]               ld_idx;
    logic [7:0]               ld_data;

    rtc_hostregs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .live      (live),
        .run       (run),
        .auto_trim (auto_trim),
        .trim      (trim),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .bus_rdata (bus_rdata)
    );

    assign trim_fire = auto_trim && (live.min == 8'h00) && (live.sec == 8'h00);

    rtc_prescaler #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .run       (run),
        .clr       (ld_en),
        .trim_fire (trim_fire),
        .trim      (trim),
        .sec_pulse (sec_pulse)
    );

    rtc_calendar u_cal (
        .clk       (clk),
        .rst       (rst),
        .sec_pulse (sec_pulse),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_data   (ld_data),
        .live      (live)
    );

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !run && !ld_en |=> $stable(live));

endmodule

// File: tb/rtc_bcd_clock_tb.sv
module rtc_bcd_clock_tb;
    localparam int PB  = 4;
    localparam int TPS = 1 << PB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int errors = 0;
    logic auto_b = 1'b0;
    logic run_b  = 1'b0;

    always #2.5 clk = ~clk;

    rtc_bcd_clock #(.PRE_BITS(PB)) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic set_ctrl(input logic r, input logic au);
        run_b = r; auto_b = au;
        wr(4'd6, {5'b0, au, 1'b0, r});
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic read_time(output logic [47:0] t);
        logic [7:0] b;
        wr(4'd6, {5'b0, auto_b, 1'b1, run_b});
        for (int i = 0; i < 6; i++) begin
            rd(4'(i), b);
            t[47 - 8*i -: 8] = b;
        end
    endtask

    task automatic load_time(input logic [47:0] t);
        set_ctrl(1'b0, auto_b);
        for (int i = 0; i < 6; i++) wr(4'(i), t[47 - 8*i -: 8]);
    endtask

    task automatic set_trim(input logic [15:0] v);
        wr(4'd7, v[7:0]);
        wr(4'd8, v[15:8]);
    endtask

    task automatic t_reset;
        logic [7:0] b;
        logic [47:0] t;
        rd(4'd6, b); chk("R1 ctrl", {40'h0, b}, 48'h0);
        rd(4'd7, b); chk("R1 trim lo", {40'h0, b}, 48'h0);
        rd(4'd8, b); chk("R1 trim hi", {40'h0, b}, 48'h0);
        rd(4'd3, b); chk("R1 day before snapshot", {40'h0, b}, 48'h01);
        read_time(t); chk("R1 R2 reset time", t, 48'h00_00_00_01_01_00);
    endtask

    task automatic t_stopped;
        logic [47:0] t;
        ticks(3 * TPS);
        read_time(t); chk("R3 stopped no count", t, 48'h00_00_00_01_01_00);
    endtask

    task automatic t_count;
        logic [47:0] t;
        load_time(48'h58_00_00_15_06_25);
        set_ctrl(1'b1, 1'b0);
        ticks(TPS - 1);
        read_time(t); chk("R4 one tick short", t, 48'h58_00_00_15_06_25);
        ticks(1);
        read_time(t); chk("R4 second step", t, 48'h59_00_00_15_06_25);
        ticks(TPS);
        read_time(t); chk("R5 minute carry", t, 48'h00_01_00_15_06_25);
    endtask

    task automatic roll(input string req, input logic [47:0] s, input logic [47:0] e);
        logic [47:0] t;
        load_time(s);
        set_ctrl(1'b1, 1'b0);
        ticks(TPS);
        read_time(t); chk(req, t, e);
    endtask

    task automatic t_snapshot;
        logic [7:0] b;
        logic [47:0] t;
        load_time(48'h10_00_00_01_01_25);
        set_ctrl(1'b1, 1'b0);
        read_time(t);
        ticks(2 * TPS);
        rd(4'd0, b); chk("R8 copy not live", {40'h0, b}, 48'h10);
        rd(4'd6, b); chk("R8 snapshot bit reads 0", {40'h0, b}, 48'h01);
        read_time(t); chk("R8 new snapshot", t, 48'h12_00_00_01_01_25);
    endtask

    task automatic t_run_write;
        logic [47:0] t;
        load_time(48'h20_00_00_01_01_25);
        set_ctrl(1'b1, 1'b0);
        wr(4'd0, 8'h45);
        wr(4'd5, 8'h77);
        read_time(t); chk("R3 write while running ignored", t, 48'h20_00_00_01_01_25);
    endtask

    task automatic t_trim_regs;
        logic [7:0] b;
        wr(4'd7, 8'h34);
        rd(4'd7, b); chk("R9 low byte staged only", {40'h0, b}, 48'h00);
        wr(4'd8, 8'h12);
        rd(4'd7, b); chk("R9 low commits", {40'h0, b}, 48'h34);
        rd(4'd8, b); chk("R9 high commits", {40'h0, b}, 48'h12);
        set_trim(16'h7FFF);
        rd(4'd7, b); chk("R9 0x7FFF rejected lo", {40'h0, b}, 48'h34);
        rd(4'd8, b); chk("R9 0x7FFF rejected hi", {40'h0, b}, 48'h12);
        set_trim(16'h7FFE);
        rd(4'd8, b); chk("R9 0x7FFE accepted", {40'h0, b}, 48'h7F);
    endtask

    task automatic trim_case(input string req, input logic [15:0] v, input int extra);
        logic [47:0] t;
        set_trim(v);
        auto_b = 1'b1;
        load_time(48'h00_00_05_01_01_25);
        set_ctrl(1'b1, 1'b1);
        ticks(TPS);
        read_time(t); chk({req, " first step"}, t, 48'h01_00_05_01_01_25);
        if (TPS + extra > 1) begin
            ticks(TPS + extra - 1);
            read_time(t); chk({req, " one tick short"}, t, 48'h01_00_05_01_01_25);
            ticks(1);
        end else begin
            ticks(1);
        end
        read_time(t); chk({req, " trimmed step"}, t, 48'h02_00_05_01_01_25);
        ticks(TPS);
        read_time(t); chk({req, " next normal"}, t, 48'h03_00_05_01_01_25);
    endtask

    task automatic t_trim_other_minute;
        logic [47:0] t;
        set_trim(16'h0005);
        auto_b = 1'b1;
        load_time(48'h00_01_05_01_01_25);
        set_ctrl(1'b1, 1'b1);
        ticks(2 * TPS);
        read_time(t); chk("R10 no trim outside minute 00", t, 48'h02_01_05_01_01_25);
    endtask

    task automatic t_trim_off;
        logic [47:0] t;
        set_trim(16'h0005);
        auto_b = 1'b0;
        load_time(48'h00_00_05_01_01_25);
        set_ctrl(1'b1, 1'b0);
        ticks(2 * TPS - 1);
        read_time(t); chk("R11 auto off short", t, 48'h01_00_05_01_01_25);
        ticks(1);
        read_time(t); chk("R11 auto off normal", t, 48'h02_00_05_01_01_25);
    endtask

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_stopped();
        t_count();
        roll("R5 hour carry",         48'h59_59_00_10_03_25, 48'h00_00_01_10_03_25);
        roll("R5 R6 day end Jan",     48'h59_59_23_31_01_25, 48'h00_00_00_01_02_25);
        roll("R6 day 30 in Jan",      48'h59_59_23_30_01_25, 48'h00_00_00_31_01_25);
        roll("R6 April 30",           48'h59_59_23_30_04_25, 48'h00_00_00_01_05_25);
        roll("R6 year carry",         48'h59_59_23_31_12_25, 48'h00_00_00_01_01_26);
        roll("R6 year 99 wrap",       48'h59_59_23_31_12_99, 48'h00_00_00_01_01_00);
        roll("R7 Feb 28 common year", 48'h59_59_23_28_02_23, 48'h00_00_00_01_03_23);
        roll("R7 Feb 28 leap year",   48'h59_59_23_28_02_24, 48'h00_00_00_29_02_24);
        roll("R7 Feb 29 leap year",   48'h59_59_23_29_02_24, 48'h00_00_00_01_03_24);
        roll("R7 year 00 is leap",    48'h59_59_23_28_02_00, 48'h00_00_00_29_02_00);
        t_snapshot();
        t_run_write();
        t_trim_regs();
        trim_case("R10 positive trim", 16'h0005, 5);
        trim_case("R10 negative trim", 16'hFFFD, -3);
        trim_case("R10 saturated trim", 16'hFF9C, 1 - TPS);
        t_trim_other_minute();
        t_trim_off();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule